// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Interrupt

This block holds characters from a serial receiver until software reads them. Each stored word is 12 bits wide. Bits [7:0] hold the character, bit 8 is the framing error, bit 9 the parity error, bit 10 the line-break marker and bit 11 the overrun marker. Words arrive on a valid/ready push port. A separate break strobe inserts a break marker word. A one-cycle pop strobe stands for a read of the data register. The word at the head is shown on `rd_data` all the time. Each pop also latches that word's four status bits into `rx_status`.

The `fifo_en` input selects the capacity at run time. When it is high the buffer holds 16 words, and when it is low it holds a single word. Any change of `fifo_en` empties the buffer. `rx_irq` is a level that goes high when a push brings the occupancy up to the trigger level, which is fixed at 1. It goes low when a pop leaves the occupancy one below that level. Back-pressure is plain: a word is taken only in a cycle where `in_valid` and `in_ready` are both high. The sender must hold its word until that happens.

Top module: `uart_rxbuf`

## Requirements
- R1: `in_ready` is high exactly when the occupancy is below the effective capacity, `fifo_en` has not changed in this cycle and `brk_evt` is low. A word is stored only when `in_valid` and `in_ready` are both high, and the occupancy never exceeds 16.
- R2: When `brk_evt` is high and the occupancy is below the capacity, the word 0x400 (character 0, only bit 10 set) is stored. This has priority over `in_valid`. When the buffer is full, the break is dropped.
- R3: Words leave in arrival order. `rd_data` shows the oldest stored word, and each pop of a non-empty buffer removes it. The storage wraps around across many fill and drain rounds.
- R4: `empty` is high when the occupancy is 0. `full` is high when the occupancy equals the effective capacity. The two are never high together.
- R5: A pop while the buffer is empty leaves the occupancy and the read position unchanged, so `rd_data` keeps showing the same stale word.
- R6: A pop and an accepted push in the same cycle on a non-empty buffer leave the occupancy unchanged. The popped word is the old head, and the pushed word joins at the tail.
- R7: In the cycle after any pop (including a pop on an empty buffer), `rx_status` equals bits [11:8] of the `rd_data` value that was present when the pop was issued. No other event changes `rx_status`.
- R8: `rx_irq` rises when an accepted push makes the occupancy equal to 1. It falls on a pop that leaves the occupancy at 0, and this includes a pop on an empty buffer. If a push and a pop together end at occupancy 1, `rx_irq` ends high.
- R9: A cycle in which `fifo_en` differs from its previous value empties the buffer and resets the read position. Any push or pop in that cycle is discarded. `rx_irq` and `rx_status` keep their values.
- R10: With `fifo_en` low the capacity is one word, so `full` rises after a single push and a second push is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 16-word capacity, 0: single word |
| in_valid | input | 1 | Push word valid |
| in_ready | output | 1 | Buffer can take the push word |
| in_data | input | 8 | Received character |
| in_err | input | 4 | Status bits {overrun, break, parity, framing} |
| brk_evt | input | 1 | Line-break strobe, stores a break marker |
| rd_pop | input | 1 | Data register read strobe |
| rd_data | output | 12 | Word at the read position |
| rx_status | output | 4 | Status bits of the last popped word |
| full | output | 1 | Occupancy equals capacity |
| empty | output | 1 | Occupancy is zero |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The assertions are checked on every cycle. They cover the following:
- the flags are never both high, and `in_ready` is never high while `full` is high;
- a mode change always leaves the buffer empty;
- `rx_irq` rises only after an accepted push;
- a pop copies the head word's status bits into `rx_status`;
- a pop on an empty buffer leaves both the occupancy and `rd_data` unchanged.

Only the bench scenarios can show the rest. That covers the order of words across wrap-around in both capacities, the refused pushes at the capacity limit, and the net-zero push/pop cycle. It also covers the fact that `rx_irq` survives a flush and is then cleared by a pop on the empty buffer.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  localparam int CHAR_W = 8;
  localparam int FLAG_W = 4;
  localparam int WORD_W = CHAR_W + FLAG_W;

  // Status bits sit above the character, ordered {ovr, brk, par, frm}.
  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              par;
    logic              frm;
    logic [CHAR_W-1:0] ch;
  } rx_word_t;

  function automatic rx_word_t break_marker();
    rx_word_t w;
    w     = '0;
    w.brk = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rxbuf_mem.sv
module rxbuf_mem
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rx_word_t      wdata,
  input  logic [AW-1:0] raddr,
  output rx_word_t      rdata
);
  rx_word_t slots [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (we) begin
      slots[waddr] <= wdata;
    end
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          accept,
  output logic          push,
  output logic          pop,
  output logic          pop_eff,
  output logic          toggle,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic          mode_q;
  logic [CW-1:0] cap;
  logic [AW-1:0] mask;

  assign toggle  = (fifo_en != mode_q);
  assign cap     = mode_q ? CW'(DEPTH) : CW'(1);
  assign mask    = mode_q ? AW'(DEPTH - 1) : '0;
  assign accept  = (count < cap) && !toggle;
  assign push    = accept && push_req;
  assign pop     = pop_req && !toggle;
  assign pop_eff = pop && (count != '0);
  assign waddr   = (rptr + AW'(count)) & mask;
  assign full    = (count == cap);
  assign empty   = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      rptr   <= '0;
      count  <= '0;
    end else begin
      mode_q <= fifo_en;
      if (toggle) begin
        rptr  <= '0;
        count <= '0;
      end else begin
        if (pop_eff) rptr <= (rptr + AW'(1)) & mask;
        count <= count + CW'(push) - CW'(pop_eff);
      end
    end
  end
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq
  import uart_rxbuf_pkg::*;
#(
  parameter int TRIG = 1,
  parameter int CW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              pop_eff,
  input  logic [CW-1:0]     count,
  input  logic [FLAG_W-1:0] head_flags,
  output logic              irq,
  output logic [FLAG_W-1:0] status
);
  logic [CW-1:0] after_pop;
  logic          at_trig;

  // Pop is ordered before push; both events test the same level.
  assign after_pop = count - CW'(pop_eff);
  assign at_trig   = (int'(after_pop) + 1 == TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      status <= '0;
    end else begin
      if (push && at_trig)     irq <= 1'b1;
      else if (pop && at_trig) irq <= 1'b0;
      if (pop) status <= head_flags;
    end
  end
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH    = 16, // power of two
  parameter int TRIG_LVL = 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic [FLAG_W-1:0] in_err,
  input  logic              brk_evt,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_data,
  output logic [FLAG_W-1:0] rx_status,
  output logic              full,
  output logic              empty,
  output logic              rx_irq
);
  logic          accept_w, push_w, pop_w, pop_eff_w, tog_w;
  logic [AW-1:0] rptr_w, waddr_w;
  logic [CW-1:0] cnt_w;
  rx_word_t      wword, head;

  assign wword    = brk_evt ? break_marker() : rx_word_t'({in_err, in_data});
  assign in_ready = accept_w && !brk_evt;
  assign rd_data  = head;

  rxbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push_req(in_valid || brk_evt), .pop_req(rd_pop),
    .accept(accept_w), .push(push_w), .pop(pop_w), .pop_eff(pop_eff_w),
    .toggle(tog_w), .rptr(rptr_w), .waddr(waddr_w), .count(cnt_w),
    .full(full), .empty(empty)
  );

  rxbuf_mem #(.DEPTH(DEPTH)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(push_w), .waddr(waddr_w),
    .wdata(wword), .raddr(rptr_w), .rdata(head)
  );

  rxbuf_irq #(.TRIG(TRIG_LVL), .CW(CW)) irq_i (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
    .pop_eff(pop_eff_w), .count(cnt_w),
    .head_flags(head[WORD_W-1:CHAR_W]), .irq(rx_irq), .status(rx_status)
  );
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          in_ready,
  input logic          rd_pop,
  input logic [11:0]   rd_data,
  input logic [3:0]    rx_status,
  input logic          full,
  input logic          empty,
  input logic          rx_irq,
  input logic [CW-1:0] count,
  input logic          push,
  input logic          toggle
);
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !full);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> empty);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(push));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && empty && !push && !toggle) |=> (empty && $stable(rd_data)));

  assert_status_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !toggle) |=> (rx_status == $past(rd_data[11:8])));

  assert_single_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !toggle && !empty) |-> full);
endmodule

bind uart_rxbuf rxbuf_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .in_ready(in_ready),
  .rd_pop(rd_pop), .rd_data(rd_data), .rx_status(rx_status),
  .full(full), .empty(empty), .rx_irq(rx_irq), .count(cnt_w),
  .push(push_w), .toggle(tog_w)
);

// File: tb/uart_rxbuf_tb_top.sv
module uart_rxbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0, in_valid = 1'b0, brk_evt = 1'b0, rd_pop = 1'b0;
  logic [7:0]  in_data = '0;
  logic [3:0]  in_err = '0;
  logic        in_ready, full, empty, rx_irq;
  logic [11:0] rd_data;
  logic [3:0]  rx_status;

  int checks = 0, fails = 0;

  // behavioural reference state
  logic [11:0] m_mem [16];
  int          m_rp = 0, m_cnt = 0;
  logic        m_mode = 1'b0, m_irq = 1'b0;
  logic [3:0]  m_stat = '0;

  always #5 clk = ~clk;

  uart_rxbuf dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_err(in_err),
    .brk_evt(brk_evt), .rd_pop(rd_pop), .rd_data(rd_data),
    .rx_status(rx_status), .full(full), .empty(empty), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cap();
    return m_mode ? 16 : 1;
  endfunction

  // Drive inputs, compare all outputs before the edge, then advance the model.
  task automatic step(input logic en, input logic v, input logic [7:0] d,
                      input logic [3:0] e, input logic b, input logic p);
    logic tog, pushed;
    logic [11:0] w;
    fifo_en = en; in_valid = v; in_data = d; in_err = e; brk_evt = b; rd_pop = p;
    #1;
    tog = (en != m_mode);
    chk("R1 in_ready", in_ready, (m_cnt < cap()) && !tog && !b);
    chk("R3 rd_data", rd_data, m_mem[m_rp]);
    chk("R4 empty", empty, m_cnt == 0);
    chk("R4 full", full, m_cnt == cap());
    chk("R8 rx_irq", rx_irq, m_irq);
    chk("R7 rx_status", rx_status, m_stat);
    @(posedge clk);
    if (tog) begin
      m_cnt = 0; m_rp = 0; m_mode = en;
    end else begin
      pushed = (v || b) && (m_cnt < cap());
      w = b ? 12'h400 : {e, d};
      if (p) begin
        m_stat = m_mem[m_rp][11:8];
        if (m_cnt > 0) begin m_rp = (m_rp + 1) % cap(); m_cnt--; end
        if (m_cnt + 1 == 1) m_irq = 1'b0;
      end
      if (pushed) begin
        m_mem[(m_rp + m_cnt) % cap()] = w;
        m_cnt++;
        if (m_cnt == 1) m_irq = 1'b1;
      end
    end
    #2;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // reset state
    chk("R4 reset empty", empty, 1'b1);
    chk("R8 reset irq", rx_irq, 1'b0);
    chk("R3 reset rd_data", rd_data, 12'h000);

    // R10 single-entry mode
    step(0, 1, 8'h41, 4'h0, 0, 0);
    chk("R10 full after one push", full, 1'b1);
    chk("R10 second push refused", in_ready, 1'b0);
    step(0, 1, 8'h42, 4'h0, 0, 0);
    chk("R10 head kept", rd_data, 12'h041);
    step(0, 0, 0, 0, 0, 1);
    step(0, 1, 8'h43, 4'h1, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R7 framing status", rx_status, 4'h1);

    // R9 mode change, push in that cycle discarded
    step(1, 1, 8'h55, 4'h0, 0, 0);
    chk("R9 push discarded on toggle", empty, 1'b1);

    // R3 fill to 16, overflow refused, drain; several rounds for wrap
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 17; i++) step(1, 1, 8'(r * 32 + i), 4'h0, 0, 0);
      chk("R1 full at 16", full, 1'b1);
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 1);
      chk("R3 order after wrap", rd_data, 12'(r * 32 + 5));
      for (int i = 0; i < 3; i++) step(1, 1, 8'hA0 + 8'(i), 4'h0, 0, 1);
      chk("R6 net zero occupancy", full, 1'b0);
      for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 1);
    end

    // R5 pop on empty keeps stale word, clears nothing else
    step(1, 0, 0, 0, 0, 1);
    chk("R5 still empty", empty, 1'b1);

    // R2 break marker and status copy
    step(1, 1, 8'h77, 4'h0, 1, 0);
    chk("R2 break word", rd_data, 12'h400);
    step(1, 0, 0, 0, 0, 1);
    chk("R7 break status", rx_status, 4'h4);

    // R8 push+pop ending at occupancy 1 keeps irq high
    step(1, 1, 8'h10, 4'h0, 0, 0);
    step(1, 1, 8'h11, 4'h0, 0, 1);
    chk("R6 R8 irq kept", rx_irq, 1'b1);

    // R9 toggle with data present keeps irq, then empty pop clears it
    step(1, 1, 8'h12, 4'h0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R9 flushed", empty, 1'b1);
    chk("R9 irq kept across flush", rx_irq, 1'b1);
    step(0, 0, 0, 0, 0, 1);
    chk("R8 R5 empty pop clears irq", rx_irq, 1'b0);

    // mixed stimulus across both modes
    for (int i = 0; i < 3000; i++) begin
      logic en;
      en = ((i / 400) % 2) == 0;
      if ((i % 400) == 200 && !empty) en = ~m_mode;
      step(en, ($urandom % 3) != 0, 8'($urandom), 4'($urandom), ($urandom % 23) == 0,
           ($urandom % 2) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule